// File: doc/BRIEF.md
# Self-Timed Fuse Word Reader

This block is a register-mapped controller for a small one-time-programmable fuse array. Software starts a read with one write to a control register. That write carries an enable bit, a read-request bit and a word address. An internal sequencer then counts out a fixed sense time, loads the selected 32-bit word into a data register and raises a completion flag. Software polls the flag, collects the word and clears the flag by writing a one to it.

The array holds 128 bytes as 32 words of 32 bits. Word N covers bytes 4N to 4N+3. The lower 96 bytes hold secure content and the upper 32 bytes are open, but this block applies no access policy. The array contents come from a parameter. The sense time is a parameter in clock cycles, and it must stay well inside the 4 µs that software allows before it treats a missing flag as an I/O error.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After reset the completion flag (status offset 0x18, bit 0) reads 0 and the data register (offset 0x20) reads 0.
- R2: A read starts only from a write to offset 0x24 with bit 0 (enable) and bit 1 (read request) both 1. A write with only one of them set starts nothing, and neither the flag nor the data register changes.
- R3: In an accepted request, bits [25:16] of the write select the word address. The flag stays clear for LATENCY-1 cycles after the write edge and is set on the LATENCY-th clock edge after it. In that same edge the data register takes the selected word.
- R4: Word N is bits [32N+31:32N] of the FUSE_IMAGE parameter.
- R5: A word address of WORDS or above returns a data word of zero and still sets the flag.
- R6: Writing 1 to bit 0 of the status offset clears the flag. Writing 0 there leaves it unchanged.
- R7: A request written while a read is in progress is ignored. The running read completes with its own address and timing, and no second completion follows.
- R8: The data register changes only on a completion. While a later read is in progress it still holds the previous word.
- R9: If a completion and a write-one-to-clear of the flag fall on the same clock edge, the completion wins and the flag reads 1.
- R10: Reads of the status offset return 0 in bits [31:1]. Reads of the control offset and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |

## Verification
The completion of a read and the software clear of the flag can land on the same clock edge. The bench provokes this by counting cycles from the accepted request and issuing the clear write so that it hits the exact edge on which the sequencer finishes. The flag must then read 1, and a later clear must take it to 0. A second collision is also exercised: a fresh request written while the sequencer is counting. The bench judges it by the data word and the finish time of the first request, and by the absence of a later completion.

// File: rtl/fuse_autoread_pkg.sv
package fuse_autoread_pkg;
  localparam int BUS_AW = 8;
  localparam logic [BUS_AW-1:0] OFF_STATUS = 8'h18;
  localparam logic [BUS_AW-1:0] OFF_DOUT   = 8'h20;
  localparam logic [BUS_AW-1:0] OFF_AUTO   = 8'h24;
  localparam int WADDR_LSB = 16;
  localparam int WADDR_W   = 10;

  typedef struct packed {
    logic latchAddr;
    logic capture;
  } fuseStrobe_t;

  typedef enum logic {
    ST_IDLE,
    ST_SENSE
  } seqState_t;
endpackage

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_autoread_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [1:0]        reqBits,
  output fuseStrobe_t       strb,
  output logic              busy
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             startReq;

  // Enable and read request must both be set in the same write.
  assign startReq = busWrEn && (busAddr == OFF_AUTO) && (reqBits == 2'b11);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startReq) begin
          state <= ST_SENSE;
          cnt   <= CNT_W'(LATENCY - 1);
        end
        ST_SENSE: if (cnt == '0) begin
          state <= ST_IDLE;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchAddr = (state == ST_IDLE) && startReq;
    strb.capture   = (state == ST_SENSE) && (cnt == '0);
  end
  assign busy = (state == ST_SENSE);

  // R7: while counting, nothing on the bus reloads or restarts the sequencer
  a_r7_busy_ignores_request: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SENSE && cnt != '0) |=> (state == ST_SENSE && cnt == $past(cnt) - CNT_W'(1)));

  // R2: an idle sequencer stays idle unless a write to the control offset sets both bits
  a_r2_needs_both_bits: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(busWrEn && busAddr == OFF_AUTO && reqBits[0] && reqBits[1]))
      |=> state == ST_IDLE);

  // R3: one capture per accepted request
  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);
endmodule

// File: rtl/fuse_datapath.sv
module fuse_datapath
  import fuse_autoread_pkg::*;
#(
  parameter int                  WORDS      = 32,
  parameter logic [WORDS*32-1:0] FUSE_IMAGE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  fuseStrobe_t        strb,
  input  logic               busWrEn,
  input  logic [BUS_AW-1:0]  busAddr,
  input  logic [WADDR_W-1:0] wordAddr,
  input  logic               clrBit,
  output logic [31:0]        busRdata
);
  localparam int IDX_W = (WORDS < 2) ? 1 : $clog2(WORDS);
  localparam logic [WADDR_W:0] WORDS_L = WORDS[WADDR_W:0];

  logic [31:0]        fuseMem [WORDS];
  logic [WADDR_W-1:0] addrQ;
  logic [31:0]        doutQ;
  logic               finishQ;
  logic               inRange;
  logic [31:0]        senseWord;
  logic               clrWrite;

  for (genvar g = 0; g < WORDS; g++) begin : g_unpack
    assign fuseMem[g] = FUSE_IMAGE[g*32 +: 32];
  end

  assign inRange   = ({1'b0, addrQ} < WORDS_L);
  assign senseWord = inRange ? fuseMem[addrQ[IDX_W-1:0]] : '0;
  assign clrWrite  = busWrEn && (busAddr == OFF_STATUS) && clrBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      doutQ   <= '0;
      finishQ <= 1'b0;
    end else begin
      if (strb.latchAddr) addrQ <= wordAddr;
      if (strb.capture)   doutQ <= senseWord;
      // completion takes priority over a same-edge clear
      if (strb.capture)   finishQ <= 1'b1;
      else if (clrWrite)  finishQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFF_STATUS: busRdata = {31'b0, finishQ};
      OFF_DOUT:   busRdata = doutQ;
      default:    busRdata = '0;
    endcase
  end

  // R6: a clear write without a completion drops the flag
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !strb.capture) |=> !finishQ);

  // R9: completion wins over a same-edge clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> finishQ);

  // R8: data register moves only on a capture
  a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(doutQ));

  // R5: out-of-range addresses sense zero
  a_r5_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !inRange) |=> doutQ == '0);

  // R3: the flag only rises from a sequencer capture
  a_r3_rise_from_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(finishQ) |-> $past(strb.capture));
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl
  import fuse_autoread_pkg::*;
#(
  parameter int                  WORDS      = 32,
  parameter int                  LATENCY    = 8,
  parameter logic [WORDS*32-1:0] FUSE_IMAGE = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  fuseStrobe_t strb;
  logic        busy;
  logic        unusedWdata;

  assign unusedWdata = ^{busWdata[31:26], busWdata[15:2], busy};

  fuse_seq_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .reqBits (busWdata[1:0]),
    .strb    (strb),
    .busy    (busy)
  );

  fuse_datapath #(.WORDS(WORDS), .FUSE_IMAGE(FUSE_IMAGE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .wordAddr (busWdata[WADDR_LSB +: WADDR_W]),
    .clrBit   (busWdata[0]),
    .busRdata (busRdata)
  );
endmodule

// File: tb/fuse_autoread_ctrl_tb.sv
module fuse_autoread_ctrl_tb;
  localparam int LAT = 6;
  localparam logic [7:0] A_STAT = 8'h18, A_DOUT = 8'h20, A_AUTO = 8'h24;

  function automatic logic [31:0] imgWord(int i);
    return {8'(i * 9 + 3), 8'(255 - i), 8'(i), 8'hC3};
  endfunction

  function automatic logic [1023:0] buildImage();
    logic [1023:0] v;
    v = '0;
    for (int i = 0; i < 32; i++) v[i*32 +: 32] = imgWord(i);
    return v;
  endfunction

  localparam logic [1023:0] TB_IMAGE = buildImage();

  function automatic logic [31:0] expWord(logic [31:0] ctrl);
    int a;
    a = int'(ctrl[25:16]);
    return (a < 32) ? imgWord(a) : 32'h0;
  endfunction

  localparam int NV = 9;
  localparam logic [31:0] VEC_CTRL [NV] = '{
    32'h0000_0003, 32'h0007_0003, 32'h001F_0003, 32'h0020_0003, 32'h03FF_0003,
    32'h0004_0001, 32'h0004_0002, 32'h000C_0003, 32'hFC02_FFFF };
  localparam logic VEC_GO [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fuse_autoread_ctrl #(.WORDS(32), .LATENCY(LAT), .FUSE_IMAGE(TB_IMAGE)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at the following negedge
  task automatic writeReg(logic [7:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0; busWdata = '0;
  endtask

  task automatic readReg(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r, prevDout;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readReg(A_STAT, r); check("R1 flag after reset", r, 32'h0);
    readReg(A_DOUT, r); check("R1 dout after reset", r, 32'h0);
    prevDout = 32'h0;

    // vector walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      writeReg(A_STAT, 32'h1);
      writeReg(A_AUTO, VEC_CTRL[v]);
      waitN(LAT - 1);
      readReg(A_STAT, r); check("R3 flag still clear before latency", r, 32'h0);
      waitN(1);
      readReg(A_STAT, r); check(VEC_GO[v] ? "R3 flag set at latency" : "R2 no start", r, {31'b0, VEC_GO[v]});
      readReg(A_DOUT, r);
      if (VEC_GO[v]) begin
        check(int'(VEC_CTRL[v][25:16]) >= 32 ? "R5 out-of-range word" : "R4 word data", r, expWord(VEC_CTRL[v]));
        prevDout = expWord(VEC_CTRL[v]);
      end else begin
        check("R2 dout unchanged", r, prevDout);
      end
    end

    // R6: writing 0 keeps the flag, writing 1 clears it; R10 read map
    readReg(A_STAT, r); check("R6 flag before clear", r, 32'h1);
    writeReg(A_STAT, 32'hFFFF_FFFE);
    readReg(A_STAT, r); check("R6 zero write keeps flag", r, 32'h1);
    readReg(A_AUTO, r); check("R10 control offset reads zero", r, 32'h0);
    readReg(8'h1C, r);  check("R10 unmapped offset reads zero", r, 32'h0);
    writeReg(A_STAT, 32'h1);
    readReg(A_STAT, r); check("R6 one write clears flag", r, 32'h0);

    // R9: clear on the completion edge
    writeReg(A_AUTO, 32'h0005_0003);
    waitN(LAT - 1);
    writeReg(A_STAT, 32'h1);
    readReg(A_STAT, r); check("R9 completion wins over clear", r, 32'h1);
    readReg(A_DOUT, r); check("R9 data with collision", r, imgWord(5));
    writeReg(A_STAT, 32'h1);
    readReg(A_STAT, r); check("R9 later clear works", r, 32'h0);

    // R7: second request while busy
    writeReg(A_AUTO, 32'h0003_0003);
    waitN(2);
    writeReg(A_AUTO, 32'h0011_0003);
    waitN(LAT - 4);
    readReg(A_STAT, r); check("R7 first read timing kept", r, 32'h0);
    waitN(1);
    readReg(A_STAT, r); check("R7 first read completes", r, 32'h1);
    readReg(A_DOUT, r); check("R7 first address kept", r, imgWord(3));
    writeReg(A_STAT, 32'h1);
    waitN(LAT + 2);
    readReg(A_STAT, r); check("R7 no second completion", r, 32'h0);
    readReg(A_DOUT, r); check("R7 dout not overwritten", r, imgWord(3));

    // R8: dout holds during a later read
    writeReg(A_AUTO, 32'h0009_0003);
    waitN(LAT - 1);
    readReg(A_DOUT, r); check("R8 dout held while busy", r, imgWord(3));
    waitN(1);
    readReg(A_DOUT, r); check("R8 dout updates at completion", r, imgWord(9));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule